// File: doc/BRIEF.md
# Funnel-Extension Logarithmic Shifter

This block is a purely combinational 32-bit shifter and rotator. It performs logical left shift, logical right shift, arithmetic right shift and rotate right, and all four share one network that can only shift right. The network has five cascaded stages. Each stage either passes its input through or moves it right by 16, 8, 4, 2 or 1 places, and each stage is steered by one bit of the 5-bit amount.

Before the network, the operand is widened to a 63-bit funnel word. The 31 bits added to the operand depend on the operation. They are the bits that move into the vacated positions as the word slides right: zeros, copies of the sign bit, or the operand's own low bits for a rotate. A left shift puts the operand in the upper half of the funnel with zeros below it. It then uses the bitwise inverse of the amount, so a left shift by k becomes a right shift by 31−k. The result is the low 32 bits after the last stage.

The block sits in an ALU beside the adder and logic unit. It is used wherever a shift or rotate result must be available in the same cycle as its operands.

Top module: `funnel_shifter`

## Requirements
- R1: With op = 2'b00 (logical left), out equals data shifted left by amount, and the low amount bits of out are zero.
- R2: With op = 2'b01 (logical right), out equals data shifted right by amount, and the upper amount bits of out are zero.
- R3: With op = 2'b10 (arithmetic right), out equals data shifted right by amount, and the upper amount bits of out are copies of data[31].
- R4: With op = 2'b11 (rotate right), out equals data rotated right by amount, so bit j of out is data[(j+amount) mod 32]. The number of set bits is preserved.
- R5: An amount of 0 returns data unchanged for every op.
- R6: The block has no state. out depends only on the present data, amount and op, and settles in the same cycle in which they are applied.
- R7: An amount of 31, the largest value, is handled exactly. A logical left shift of 1 gives 32'h8000_0000. A logical right shift of 32'h8000_0000 gives 1. An arithmetic right shift of 32'h8000_0000 gives 32'hFFFF_FFFF. A rotate right of 1 gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data | input | 32 | Operand to shift or rotate |
| amount | input | 5 | Shift or rotate distance, 0 to 31 |
| op | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| out | output | 32 | Result |

## Verification
Each operation is run for every amount from 0 to 31 on fixed operands and on random ones. The fixed operands are all ones, a lone top bit, a lone bottom bit, and a value with a clear sign bit. They expose the faults that matter. If the left-shift amount is not inverted, a shift by k comes out as a shift by 31−k, which shows at amount 0 and amount 31. A wrong fill for the arithmetic shift leaves zeros where copies of the sign bit belong when the operand is negative. A wrong funnel extension for the rotate drops bits that should wrap around into the top positions. A stage tied to the wrong amount bit corrupts every amount that uses that bit.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Operation codes; the encoding is visible on the top-level op port.
    typedef enum logic [1:0] {
        SHF_SLL = 2'b00,
        SHF_SRL = 2'b01,
        SHF_SRA = 2'b10,
        SHF_ROR = 2'b11
    } shf_op_e;

    // Width of the funnel word for a given operand width.
    function automatic int funnel_width(input int w);
        return 2 * w - 1;
    endfunction

    // True when the operation fills from the upper half (left shift).
    function automatic logic is_left(input shf_op_e op);
        return op == SHF_SLL;
    endfunction

endpackage

// File: rtl/shf_extend.sv
module shf_extend
    import shf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]               data,
    input  shf_op_e                    op,
    output logic [funnel_width(W)-1:0] ext
);

    // The W-1 fill bits are what slide into vacated result positions.
    always_comb begin
        unique case (op)
            SHF_SLL: ext = {data, {(W-1){1'b0}}};
            SHF_SRL: ext = {{(W-1){1'b0}}, data};
            SHF_SRA: ext = {{(W-1){data[W-1]}}, data};
            SHF_ROR: ext = {data[W-2:0], data};
            default: ext = {{(W-1){1'b0}}, data};
        endcase
    end

endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
    parameter int OW = 32,
    parameter int SH = 1
) (
    input  logic [OW+SH-1:0] din,
    input  logic             sel,
    output logic [OW-1:0]    dout
);

    // Conditional right move by SH; the low SH bits fall off when taken,
    // the top SH bits fall off when not.
    assign dout = sel ? din[OW+SH-1:SH] : din[OW-1:0];

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import shf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         data,
    input  logic [$clog2(W)-1:0] amount,
    input  logic [1:0]           op,
    output logic [W-1:0]         out
);

    localparam int LOG = $clog2(W);
    localparam int XW  = funnel_width(W);

    shf_op_e        op_e;
    logic [XW-1:0]  ext;
    logic [LOG-1:0] amt_eff;

    assign op_e = shf_op_e'(op);

    // A left move of k is a right move of (W-1)-k through the funnel.
    assign amt_eff = is_left(op_e) ? ~amount : amount;

    shf_extend #(.W(W)) u_extend (
        .data (data),
        .op   (op_e),
        .ext  (ext)
    );

    // Stage i moves by 2**i; each stage keeps only the bits later stages can reach.
    for (genvar i = LOG - 1; i >= 0; i--) begin : g_st
        localparam int SH = 1 << i;
        localparam int OW = W + SH - 1;
        logic [OW+SH-1:0] din;
        logic [OW-1:0]    tap;
        if (i == LOG - 1) begin : g_first
            assign din = ext;
        end else begin : g_next
            assign din = g_st[i+1].tap;
        end
        shf_stage #(.OW(OW), .SH(SH)) u_stage (
            .din  (din),
            .sel  (amt_eff[i]),
            .dout (tap)
        );
    end

    assign out = g_st[0].tap;

endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
    parameter int W = 32
) (
    input logic [W-1:0]         data,
    input logic [$clog2(W)-1:0] amount,
    input logic [1:0]           op,
    input logic [W-1:0]         out
);

    logic [W-1:0] hi_mask;
    logic [W-1:0] lo_mask;

    assign hi_mask = ~({W{1'b1}} >> amount);
    assign lo_mask = ~({W{1'b1}} << amount);

    always_comb begin
        if (op == 2'b00)
            assert_sll_lowzero_R1: assert ((out & lo_mask) == '0);
        if (op == 2'b01)
            assert_srl_highzero_R2: assert ((out & hi_mask) == '0);
        if (op == 2'b10)
            assert_sra_signfill_R3: assert ((out & hi_mask) == (data[W-1] ? hi_mask : '0));
        if (op == 2'b11)
            assert_ror_popcount_R4: assert ($countones(out) == $countones(data));
        if (amount == '0)
            assert_zero_amount_R5: assert (out == data);
    end

endmodule

bind funnel_shifter funnel_shifter_chk #(.W(W)) u_chk (
    .data   (data),
    .amount (amount),
    .op     (op),
    .out    (out)
);

// File: tb/funnel_shifter_bench.sv
module funnel_shifter_bench;

    logic        clk = 1'b0;
    logic [31:0] data = '0;
    logic [4:0]  amount = '0;
    logic [1:0]  op = '0;
    logic [31:0] out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    typedef struct {
        logic [1:0]  op;
        logic [31:0] data;
        logic [4:0]  amt;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    funnel_shifter u_funnel_shifter (
        .data   (data),
        .amount (amount),
        .op     (op),
        .out    (out)
    );

    function automatic logic [31:0] ref_model(logic [1:0] o, logic [31:0] d, logic [4:0] k);
        case (o)
            2'b00:   return d << k;
            2'b01:   return d >> k;
            2'b10:   return 32'($signed(d) >>> k);
            default: return (d >> k) | (d << (6'd32 - {1'b0, k}));
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] o, logic [4:0] k);
        if (k == 5'd0) return "R5";
        case (o)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Driver: apply just after the rising edge, push the expected result.
    task automatic apply(logic [1:0] o, logic [31:0] d, logic [4:0] k, string tag);
        item_t it;
        @(posedge clk);
        #1;
        op = o; data = d; amount = k;
        it.op = o; it.data = d; it.amt = k; it.exp = ref_model(o, d, k); it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare at the falling edge, same cycle as the inputs (R6).
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (out !== it.exp) begin
                n_fail++;
                $display("FAIL %s op=%0d data=%08h amt=%0d actual=%08h expected=%08h",
                         it.tag, it.op, it.data, it.amt, out, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] fixed [4];
        logic [31:0] rnd;
        fixed[0] = 32'hFFFF_FFFF;
        fixed[1] = 32'h8000_0000;
        fixed[2] = 32'h0000_0001;
        fixed[3] = 32'h1234_5678;

        // Quiescent operand: every op of zero gives zero (R6).
        for (int o = 0; o < 4; o++) apply(2'(o), 32'h0, 5'd7, "R6");

        // Largest amount, exact values (R7).
        apply(2'b00, 32'h0000_0001, 5'd31, "R7");
        apply(2'b01, 32'h8000_0000, 5'd31, "R7");
        apply(2'b10, 32'h8000_0000, 5'd31, "R7");
        apply(2'b11, 32'h0000_0001, 5'd31, "R7");

        // Fixed operands, every op, every amount (R1 R2 R3 R4 R5).
        for (int f = 0; f < 4; f++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 32; k++)
                    apply(2'(o), fixed[f], 5'(k), tag_of(2'(o), 5'(k)));

        // Random operands.
        rnd = $urandom(32'd2024);
        for (int r = 0; r < 8; r++) begin
            rnd = $urandom;
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 32; k++)
                    apply(2'(o), rnd, 5'(k), tag_of(2'(o), 5'(k)));
        end

        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule